// File: doc/BRIEF.md
# Mixed-Width Paired Register File

This block holds the architectural registers of a 16-bit RISC datapath. It has sixteen registers, indexed 0 to 15. Indices 0 to 11 are 16-bit registers. Indices 12 and 13 are 32-bit registers. Index 14 is the 32-bit return-address register and index 15 is the 32-bit stack pointer. The block also holds the 24-bit program counter. There are two combinational read ports and one synchronous write port. Each port carries a width select, so an access is either a single 16-bit operand or a 32-bit value. A 32-bit value is used for addresses wider than 16 bits.

The `short_mode` input chooses how a 32-bit access is formed.

- **Native pairing (`short_mode` = 0):** at indices 0 to 11, two adjacent low halves are joined. The four upper registers are accessed whole.
- **Legacy pairing (`short_mode` = 1):** adjacent low halves are chained up to index 13. The pair at index 13 is the low half of the return-address register over the low half of index 13. Indices 14 and 15 are accessed whole.

The write port uses exactly the same pairing as the read ports. A value written as a pair therefore reads back as the same pair. An execution unit drives read indices from the decoded instruction and writes results back through the single write port.

Top module: `regfile_paired`

## Requirements
- R1: A synchronous active-high `rst` clears every register half and the program counter to zero. On the cycle after a reset edge, both read ports return zero and `pc_q` is zero.
- R2: A 16-bit read (`*_wide` = 0) returns the low 16 bits of register `idx` on bits 15:0. Bits 31:16 are reserved and read as zero.
- R3: A 16-bit write (`wr_wide` = 0) to any register updates only its low 16 bits from `wr_data[15:0]`. The upper half of a 32-bit register keeps its value.
- R4: With `short_mode` = 0, a 32-bit access at index n ≤ 11 covers the pair {low(n+1), low(n)}. Bits 31:16 come from index n+1. At n = 11 the upper half is the low half of index 12.
- R5: With `short_mode` = 0, a 32-bit access at index 12 to 15 covers that whole register, upper half in bits 31:16.
- R6: With `short_mode` = 1, a 32-bit access at index n ≤ 13 covers the pair {low(n+1), low(n)}. At n = 13 the upper half is the low half of the return-address register (index 14).
- R7: With `short_mode` = 1, a 32-bit access at index 14 or 15 covers that whole register.
- R8: A 32-bit write updates both halves of its pair or register on the same clock edge. The next cycle, a 32-bit read in the same mode at the same index returns the written word.
- R9: A read in the same cycle as a write to the same location returns the old value. The new value appears one cycle later, with no bypass.
- R10: When `pc_we` is 1, `pc_q` takes `pc_wdata` on the next edge. When `pc_we` is 0, `pc_q` holds its value.
- R11: The two read ports are independent. Each decodes its own index and width against the same `short_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| short_mode | input | 1 | 1 = legacy pairing, 0 = native pairing |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_wide | input | 1 | Read port A: 1 = 32-bit, 0 = 16-bit |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_wide | input | 1 | Read port B: 1 = 32-bit, 0 = 16-bit |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_wide | input | 1 | Write width: 1 = 32-bit, 0 = 16-bit |
| wr_data | input | 32 | Write data (bits 31:16 used only for 32-bit writes) |
| pc_we | input | 1 | Program counter load enable |
| pc_wdata | input | 24 | Program counter load value |
| pc_q | output | 24 | Program counter |

## Verification
The read ports are combinational, so read data is due in the same cycle as the index and width. The bench drives inputs just after a falling edge and samples one nanosecond later, before the rising edge. A write or program counter load takes effect at the next rising edge. The bench model therefore applies the write only after that edge, and the following sample sees the new value while a same-cycle read sees the old one. The checker's write-to-read property looks exactly one cycle after the write, and its reset check looks one cycle after a reset edge.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int RF_REGS       = 16;
    localparam int RF_HALF       = 16;
    localparam int RF_FIRST_WIDE = 12;
    localparam int RF_LEGACY_TOP = 13;
    localparam int RF_IDXW       = $clog2(RF_REGS);
    localparam int RF_WORD       = 2 * RF_HALF;
    localparam int RF_PCW        = 24;

    typedef enum logic [1:0] {
        HI_NONE  = 2'd0,
        HI_PAIR  = 2'd1,
        HI_UPPER = 2'd2
    } hi_kind_e;

    typedef struct packed {
        logic [RF_IDXW-1:0] lo_sel;
        logic [RF_IDXW-1:0] hi_sel;
        hi_kind_e           hi_kind;
    } pair_map_t;

    function automatic pair_map_t rf_decode(
        input logic [RF_IDXW-1:0] idx,
        input logic               wide,
        input logic               legacy
    );
        pair_map_t m;
        logic      is_pair;
        m.lo_sel  = idx;
        m.hi_sel  = idx;
        m.hi_kind = HI_NONE;
        if (legacy) begin
            is_pair = (idx <= RF_IDXW'(RF_LEGACY_TOP));
        end else begin
            is_pair = (idx < RF_IDXW'(RF_FIRST_WIDE));
        end
        if (wide) begin
            if (is_pair) begin
                m.hi_kind = HI_PAIR;
                m.hi_sel  = idx + RF_IDXW'(1);
            end else begin
                m.hi_kind = HI_UPPER;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/rf_bank.sv
module rf_bank
    import regfile_pkg::*;
#(
    parameter int NUM_REGS   = RF_REGS,
    parameter int HALF_W     = RF_HALF,
    parameter int FIRST_WIDE = RF_FIRST_WIDE,
    localparam int IDXW      = $clog2(NUM_REGS),
    localparam int NUM_UP    = NUM_REGS - FIRST_WIDE
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  pair_map_t                        wr_map,
    input  logic [2*HALF_W-1:0]              wr_data,
    output logic [NUM_REGS-1:0][HALF_W-1:0]  lo_q,
    output logic [NUM_UP-1:0][HALF_W-1:0]    hi_q
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_lo
        logic hit_lo;
        logic hit_hi;
        assign hit_lo = wr_en && (wr_map.lo_sel == IDXW'(i));
        assign hit_hi = wr_en && (wr_map.hi_kind == HI_PAIR) && (wr_map.hi_sel == IDXW'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q[i] <= '0;
            end else if (hit_lo) begin
                lo_q[i] <= wr_data[HALF_W-1:0];
            end else if (hit_hi) begin
                lo_q[i] <= wr_data[2*HALF_W-1:HALF_W];
            end
        end
    end

    for (genvar j = 0; j < NUM_UP; j++) begin : g_hi
        logic hit_up;
        assign hit_up = wr_en && (wr_map.hi_kind == HI_UPPER)
                        && (wr_map.lo_sel == IDXW'(FIRST_WIDE + j));
        always_ff @(posedge clk) begin
            if (rst) begin
                hi_q[j] <= '0;
            end else if (hit_up) begin
                hi_q[j] <= wr_data[2*HALF_W-1:HALF_W];
            end
        end
    end

endmodule

// File: rtl/rf_rdport.sv
module rf_rdport
    import regfile_pkg::*;
#(
    parameter int NUM_REGS   = RF_REGS,
    parameter int HALF_W     = RF_HALF,
    parameter int FIRST_WIDE = RF_FIRST_WIDE,
    localparam int IDXW      = $clog2(NUM_REGS),
    localparam int NUM_UP    = NUM_REGS - FIRST_WIDE,
    localparam int OFFW      = (NUM_UP > 1) ? $clog2(NUM_UP) : 1
) (
    input  logic [NUM_REGS-1:0][HALF_W-1:0] lo_q,
    input  logic [NUM_UP-1:0][HALF_W-1:0]   hi_q,
    input  pair_map_t                       map,
    output logic [2*HALF_W-1:0]             data
);

    logic [IDXW-1:0]   up_off;
    logic [HALF_W-1:0] upper_half;

    always_comb begin
        up_off = map.lo_sel - IDXW'(FIRST_WIDE);
        unique case (map.hi_kind)
            HI_PAIR:  upper_half = lo_q[map.hi_sel];
            HI_UPPER: upper_half = hi_q[up_off[OFFW-1:0]];
            default:  upper_half = '0;
        endcase
        data = {upper_half, lo_q[map.lo_sel]};
    end

endmodule

// File: rtl/rf_pc.sv
module rf_pc #(
    parameter int PC_W = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [PC_W-1:0] load_val,
    output logic [PC_W-1:0] pc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (load) begin
            pc <= load_val;
        end
    end

endmodule

// File: rtl/regfile_paired.sv
module regfile_paired
    import regfile_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                short_mode,
    input  logic [RF_IDXW-1:0]  rd_a_idx,
    input  logic                rd_a_wide,
    output logic [RF_WORD-1:0]  rd_a_data,
    input  logic [RF_IDXW-1:0]  rd_b_idx,
    input  logic                rd_b_wide,
    output logic [RF_WORD-1:0]  rd_b_data,
    input  logic                wr_en,
    input  logic [RF_IDXW-1:0]  wr_idx,
    input  logic                wr_wide,
    input  logic [RF_WORD-1:0]  wr_data,
    input  logic                pc_we,
    input  logic [RF_PCW-1:0]   pc_wdata,
    output logic [RF_PCW-1:0]   pc_q
);

    localparam int NUM_UP = RF_REGS - RF_FIRST_WIDE;
    localparam int NPORT  = 2;

    logic [RF_REGS-1:0][RF_HALF-1:0] lo_q;
    logic [NUM_UP-1:0][RF_HALF-1:0]  hi_q;
    pair_map_t                       wr_map;
    pair_map_t                       rd_map  [NPORT];
    logic [RF_IDXW-1:0]              rd_idx  [NPORT];
    logic                            rd_wide [NPORT];
    logic [RF_WORD-1:0]              rd_data [NPORT];

    assign rd_idx[0]  = rd_a_idx;
    assign rd_wide[0] = rd_a_wide;
    assign rd_idx[1]  = rd_b_idx;
    assign rd_wide[1] = rd_b_wide;
    assign rd_a_data  = rd_data[0];
    assign rd_b_data  = rd_data[1];

    assign wr_map = rf_decode(wr_idx, wr_wide, short_mode);

    rf_bank #(
        .NUM_REGS   (RF_REGS),
        .HALF_W     (RF_HALF),
        .FIRST_WIDE (RF_FIRST_WIDE)
    ) bank_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_map  (wr_map),
        .wr_data (wr_data),
        .lo_q    (lo_q),
        .hi_q    (hi_q)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rd_map[p] = rf_decode(rd_idx[p], rd_wide[p], short_mode);
        rf_rdport #(
            .NUM_REGS   (RF_REGS),
            .HALF_W     (RF_HALF),
            .FIRST_WIDE (RF_FIRST_WIDE)
        ) port_i (
            .lo_q (lo_q),
            .hi_q (hi_q),
            .map  (rd_map[p]),
            .data (rd_data[p])
        );
    end

    rf_pc #(
        .PC_W (RF_PCW)
    ) pc_i (
        .clk      (clk),
        .rst      (rst),
        .load     (pc_we),
        .load_val (pc_wdata),
        .pc       (pc_q)
    );

endmodule

// File: rtl/regfile_paired_checker.sv
module regfile_paired_checker (
    input logic        clk,
    input logic        rst,
    input logic        short_mode,
    input logic [3:0]  rd_a_idx,
    input logic        rd_a_wide,
    input logic [31:0] rd_a_data,
    input logic [3:0]  rd_b_idx,
    input logic        rd_b_wide,
    input logic [31:0] rd_b_data,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic        wr_wide,
    input logic [31:0] wr_data,
    input logic        pc_we,
    input logic [23:0] pc_wdata,
    input logic [23:0] pc_q
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: everything reads zero right after a reset edge
    always @(negedge clk) begin
        if (rst_d === 1'b1) begin
            assert_reset_clear_R1: assert (pc_q == '0 && rd_a_data == '0 && rd_b_data == '0)
                else $error("reset did not clear state");
        end
    end

    assert_narrow_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (!rd_a_wide |-> rd_a_data[31:16] == 16'h0) and (!rd_b_wide |-> rd_b_data[31:16] == 16'h0));

    // R8 (and R3 for narrow): write is visible one cycle later at the same location
    assert_write_visible_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && !wr_en && rd_a_idx == $past(wr_idx)
         && rd_a_wide == $past(wr_wide) && short_mode == $past(short_mode))
        |-> rd_a_data == (rd_a_wide ? $past(wr_data) : {16'h0, $past(wr_data[15:0])}));

    assert_pc_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !pc_we |=> $stable(pc_q));

    assert_pc_load_R10: assert property (@(posedge clk) disable iff (rst)
        pc_we |=> pc_q == $past(pc_wdata));

endmodule

bind regfile_paired regfile_paired_checker chk_i (.*);

// File: tb/regfile_paired_tb_top.sv
module regfile_paired_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        short_mode;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic        rd_a_wide, rd_b_wide, wr_wide, wr_en, pc_we;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic [23:0] pc_wdata, pc_q;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [15:0] lo_m [16];
    logic [15:0] hi_m [4];
    logic [23:0] pc_m;

    always #4 clk = ~clk;

    regfile_paired dut_i (.*);

    function automatic bit is_pair(int idx, bit sr);
        return sr ? (idx <= 13) : (idx <= 11);
    endfunction

    function automatic logic [31:0] exp_read(int idx, bit w, bit sr);
        if (!w) return {16'h0, lo_m[idx]};
        if (is_pair(idx, sr)) return {lo_m[idx+1], lo_m[idx]};
        return {hi_m[idx-12], lo_m[idx]};
    endfunction

    function automatic string req_of(int idx, bit w, bit sr);
        if (!w) return "R2";
        if (sr) return is_pair(idx, sr) ? "R6" : "R7";
        return is_pair(idx, sr) ? "R4" : "R5";
    endfunction

    task automatic model_write();
        if (wr_en) begin
            lo_m[wr_idx] = wr_data[15:0];
            if (wr_wide) begin
                if (is_pair(int'(wr_idx), short_mode)) lo_m[wr_idx+1] = wr_data[31:16];
                else hi_m[wr_idx-12] = wr_data[31:16];
            end
        end
        if (pc_we) pc_m = pc_wdata;
    endtask

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_ports(string tag);
        check({tag, req_of(int'(rd_a_idx), rd_a_wide, short_mode)}, rd_a_data,
              exp_read(int'(rd_a_idx), rd_a_wide, short_mode));
        check({tag, "R11 ", req_of(int'(rd_b_idx), rd_b_wide, short_mode)}, rd_b_data,
              exp_read(int'(rd_b_idx), rd_b_wide, short_mode));
    endtask

    // advance one clock: write lands at posedge, model follows, inputs released at negedge
    task automatic cyc();
        @(posedge clk);
        #1;
        if (!rst) model_write();
        @(negedge clk);
        wr_en = 0;
        pc_we = 0;
    endtask

    task automatic rd(logic [3:0] ai, bit aw, logic [3:0] bi, bit bw);
        rd_a_idx = ai; rd_a_wide = aw; rd_b_idx = bi; rd_b_wide = bw;
        #1;
    endtask

    task automatic wr(logic [3:0] i, bit w, logic [31:0] d);
        wr_en = 1; wr_idx = i; wr_wide = w; wr_data = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; short_mode = 0; wr_en = 0; pc_we = 0;
        wr_idx = 0; wr_wide = 0; wr_data = '1; pc_wdata = '1;
        rd_a_idx = 0; rd_a_wide = 0; rd_b_idx = 0; rd_b_wide = 0;
        foreach (lo_m[i]) lo_m[i] = '0;
        foreach (hi_m[i]) hi_m[i] = '0;
        pc_m = '0;
        @(negedge clk);
        wr_en = 1; pc_we = 1;   // ignored under reset
        cyc(); cyc();
        rst = 0;
        // R1: reset state
        rd(4'd15, 1, 4'd12, 1);
        check("R1 rd_a", rd_a_data, 32'h0);
        check("R1 rd_b", rd_b_data, 32'h0);
        check("R1 pc", {8'h0, pc_q}, 32'h0);

        // R5 native whole R12
        wr(4'd12, 1, 32'hAAAA_5555); cyc();
        rd(4'd12, 1, 4'd12, 0);
        check("R5 wide R12", rd_a_data, 32'hAAAA_5555);
        check("R2 narrow R12", rd_b_data, 32'h0000_5555);
        // R3 narrow write keeps upper half
        wr(4'd12, 0, 32'hFFFF_1234); cyc();
        rd(4'd12, 1, 4'd12, 0);
        check("R3 upper kept", rd_a_data, 32'hAAAA_1234);
        check("R3 narrow", rd_b_data, 32'h0000_1234);
        // R4 pair at 11 uses low half of R12
        wr(4'd11, 0, 32'h0000_1111); cyc();
        rd(4'd11, 1, 4'd10, 1);
        check("R4 pair 11", rd_a_data, 32'h1234_1111);
        check("R4 pair 10", rd_b_data, 32'h1111_0000);
        // R8 wide pair write, halves seen separately
        wr(4'd3, 1, 32'hBEEF_CAFE); cyc();
        rd(4'd3, 0, 4'd4, 0);
        check("R8 low half", rd_a_data, 32'h0000_CAFE);
        check("R8 high half", rd_b_data, 32'h0000_BEEF);
        // R6/R7 legacy mode
        short_mode = 1;
        wr(4'd14, 1, 32'h7777_2222); cyc();  // R7: whole RA
        wr(4'd13, 1, 32'h3333_4444); cyc();  // R6: {RA_L, R13_L}
        rd(4'd13, 1, 4'd14, 1);
        check("R6 pair 13", rd_a_data, 32'h3333_4444);
        check("R7 whole RA", rd_b_data, 32'h7777_3333);
        wr(4'd15, 1, 32'h9999_8888); cyc();
        rd(4'd15, 1, 4'd12, 1);
        check("R7 whole SP", rd_a_data, 32'h9999_8888);
        check("R6 pair 12", rd_b_data, 32'h4444_1234);
        short_mode = 0;
        rd(4'd13, 1, 4'd14, 1);
        check("R5 native R13", rd_a_data, 32'h0000_4444);
        // R9 same-cycle read sees old value
        wr(4'd5, 1, 32'h5A5A_A5A5);
        rd(4'd5, 1, 4'd6, 0);
        check("R9 old pair", rd_a_data, 32'h0);
        cyc();
        rd(4'd5, 1, 4'd6, 0);
        check("R9 new pair", rd_a_data, 32'h5A5A_A5A5);
        check("R9 new high", rd_b_data, 32'h0000_5A5A);
        // R10 program counter
        pc_we = 1; pc_wdata = 24'hABCDEF; cyc();
        check("R10 load", {8'h0, pc_q}, 32'h00AB_CDEF);
        pc_wdata = 24'h123456; cyc();
        check("R10 hold", {8'h0, pc_q}, 32'h00AB_CDEF);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            short_mode = 1'($urandom);
            wr_en      = ($urandom % 3) != 0;
            wr_idx     = 4'($urandom);
            wr_wide    = 1'($urandom);
            wr_data    = $urandom;
            pc_we      = ($urandom % 4) == 0;
            pc_wdata   = 24'($urandom);
            rd(4'($urandom), 1'($urandom), 4'($urandom), 1'($urandom));
            check_ports("rand ");
            check("R10 rand pc", {8'h0, pc_q}, {8'h0, pc_m});
            cyc();
        end
        finish_run();
    end

endmodule